// File: doc/BRIEF.md
# Decoded Micro-op Trace Line Cache

This block holds lines of already-decoded micro-ops. They are arranged in the order the program is predicted to run, not in the order of their memory addresses. A fetch pointer is looked up in a direct-mapped store. On a hit, a complete line of up to six micro-op slots goes to a downstream micro-op buffer. Each slot has its own valid bit and its own taken-branch bit. The store accepts a new lookup only every other cycle, so it runs at half the core rate.

On a miss, the block enables a decoder stub and gathers its output in a fill buffer. The stub handles one instruction per cycle and presents up to four micro-op lanes with a lane valid mask. Each instruction also carries a taken-branch tag and an end-of-trace marker. A taken branch does not close the line, so the micro-ops on the target path land in the same line as the branch. The line is written when six micro-ops have gathered or when the end marker arrives, and the fill then ends. The consumer fetches the same pointer again to read the new line. A flush invalidates every line and abandons any fill in progress.

Top module: `trace_line_cache`

## Requirements
- R1: After reset, `hit`, `miss` and `dec_en` are low, `fetch_rdy` is high, and every line is invalid, so the first lookup of any pointer misses.
- R2: A fetch accepted on a clock edge (`fetch_req` and `fetch_rdy` both high) for a pointer that is not stored raises `miss` for exactly the next cycle. `dec_en` is high from that cycle until the edge on which the line closes.
- R3: While `dec_en` is high, the valid lanes of `dec_uops` (lane k at bits [16k+15:16k], validity in `dec_mask` bit k, any mask pattern) are appended to the line in ascending lane order after the micro-ops already gathered. Decoder inputs presented while `dec_en` is low change nothing.
- R4: When the gathered count reaches six, the line is written on that edge and the fill ends. Micro-ops of that instruction beyond the sixth slot are discarded.
- R5: A taken tag does not close the line. If the last valid lane of a taken-tagged instruction was kept, the slot it landed in has its bit set in `line_tkn`.
- R6: `dec_end` closes the line on that edge with the micro-ops gathered so far, including that cycle's. Slot i (bits [16i+15:16i] of `line_uops`) is valid exactly when i is below the count, and unused slots read zero. A trace closed with no micro-ops is not stored.
- R7: A fetch accepted for a stored pointer raises `hit` for exactly the next cycle, with the stored `line_vld`, `line_tkn` and `line_uops`. `dec_en` stays low.
- R8: `fetch_rdy` is low in the cycle a line is presented and during a fill, so back-to-back lookups produce hits two cycles apart.
- R9: A line is indexed by the low log2(line count) pointer bits and tagged with the remaining upper bits. Writing a pointer with the same index but a different tag replaces the older line, and the older pointer then misses.
- R10: `flush` invalidates every line and abandons the fill in progress without writing it. In the next cycle `dec_en`, `hit` and `miss` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines and abandon any fill |
| fetch_req | input | 1 | Lookup request for `fetch_addr` |
| fetch_addr | input | 16 | Fetch pointer of the first micro-op of a line |
| fetch_rdy | output | 1 | Block can accept a lookup this cycle |
| hit | output | 1 | Line presented on the line outputs this cycle |
| miss | output | 1 | Last accepted lookup missed; refill starts |
| dec_en | output | 1 | Decoder stub enabled; refill in progress |
| dec_mask | input | 4 | Valid lanes of the decoded instruction |
| dec_uops | input | 64 | Four 16-bit micro-op lanes |
| dec_taken | input | 1 | Instruction is a predicted-taken branch |
| dec_end | input | 1 | End-of-trace marker for this instruction |
| line_vld | output | 6 | Per-slot valid bits of the presented line |
| line_tkn | output | 6 | Per-slot taken-branch bits of the presented line |
| line_uops | output | 96 | Six 16-bit micro-op slots |

## Verification
The fill path is driven with dense masks, sparse masks with gaps (1000, 0110, 0101), and an instruction that overruns the sixth slot. These show whether lane compaction, the slot ordering and the overflow discard are right. Taken tags are placed both mid-line and on the instruction that completes the line. This tells a line that wrongly closes at a branch apart from one that carries on, and shows whether the tag bit sits on the correct slot. Short traces ended by the marker, an empty trace, two pointers that share an index, back-to-back hits, decoder activity while idle, and a flush in the middle of a fill each target one of the rules for closing, replacing, pacing, ignoring and aborting.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int UOP_W     = 16;
  localparam int LINE_UOPS = 6;
  localparam int DEC_LANES = 4;
  localparam int ADDR_W    = 16;
  localparam int NLINES    = 8;

  // number of set bits of m strictly below position lane
  function automatic int ones_below(input logic [31:0] m, input int lane);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < lane && m[i]) c++;
    end
    return c;
  endfunction

  // index of the highest set bit, zero when empty
  function automatic int top_lane(input logic [31:0] m);
    int t;
    t = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) t = i;
    end
    return t;
  endfunction

  // thermometer mask with the n low bits set
  function automatic logic [31:0] low_mask(input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i < n);
    return r;
  endfunction
endpackage

// File: rtl/tc_pack.sv
module tc_pack
  import tc_pkg::*;
#(
  parameter int LINE_UOPS = tc_pkg::LINE_UOPS,
  parameter int DEC_LANES = tc_pkg::DEC_LANES,
  localparam int CNT_W  = $clog2(LINE_UOPS + 1),
  localparam int POS_W  = $clog2(LINE_UOPS + DEC_LANES + 1),
  localparam int LANE_W = (DEC_LANES > 1) ? $clog2(DEC_LANES) : 1
) (
  input  logic [CNT_W-1:0]                 base,
  input  logic [DEC_LANES-1:0]             mask,
  output logic [DEC_LANES-1:0][POS_W-1:0]  lane_pos,
  output logic [DEC_LANES-1:0]             lane_keep,
  output logic [CNT_W-1:0]                 new_cnt,
  output logic [POS_W-1:0]                 brk_pos,
  output logic                             brk_keep
);
  logic [POS_W-1:0]  sum;
  logic [LANE_W-1:0] top;

  for (genvar l = 0; l < DEC_LANES; l++) begin : g_lane
    assign lane_pos[l]  = POS_W'(base) + POS_W'(ones_below(32'(mask), l));
    assign lane_keep[l] = mask[l] && (lane_pos[l] < POS_W'(LINE_UOPS));
  end

  assign sum      = POS_W'(base) + POS_W'(ones_below(32'(mask), DEC_LANES));
  assign new_cnt  = (sum > POS_W'(LINE_UOPS)) ? CNT_W'(LINE_UOPS) : CNT_W'(sum);
  assign top      = LANE_W'(top_lane(32'(mask)));
  assign brk_pos  = lane_pos[top];
  assign brk_keep = (mask != '0) && lane_keep[top];
endmodule

// File: rtl/tc_fill.sv
module tc_fill
  import tc_pkg::*;
#(
  parameter int LINE_UOPS = tc_pkg::LINE_UOPS,
  parameter int DEC_LANES = tc_pkg::DEC_LANES,
  parameter int UOP_W     = tc_pkg::UOP_W,
  localparam int CNT_W = $clog2(LINE_UOPS + 1),
  localparam int POS_W = $clog2(LINE_UOPS + DEC_LANES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          step,
  input  logic [DEC_LANES-1:0]          dec_mask,
  input  logic [DEC_LANES*UOP_W-1:0]    dec_uops,
  input  logic                          dec_taken,
  input  logic                          dec_end,
  output logic                          commit,
  output logic                          store,
  output logic [LINE_UOPS-1:0]          out_vld,
  output logic [LINE_UOPS-1:0]          out_tkn,
  output logic [LINE_UOPS*UOP_W-1:0]    out_uops
);
  logic [CNT_W-1:0]                cnt_q;
  logic [LINE_UOPS*UOP_W-1:0]      uops_q;
  logic [LINE_UOPS-1:0]            tkn_q;
  logic [DEC_LANES-1:0][POS_W-1:0] lane_pos;
  logic [DEC_LANES-1:0]            lane_keep;
  logic [CNT_W-1:0]                new_cnt;
  logic [POS_W-1:0]                brk_pos;
  logic                            brk_keep;
  logic [LINE_UOPS*UOP_W-1:0]      m_uops;
  logic [LINE_UOPS-1:0]            m_tkn;

  tc_pack #(.LINE_UOPS(LINE_UOPS), .DEC_LANES(DEC_LANES)) u_pack (
    .base(cnt_q), .mask(dec_mask), .lane_pos(lane_pos), .lane_keep(lane_keep),
    .new_cnt(new_cnt), .brk_pos(brk_pos), .brk_keep(brk_keep)
  );

  // merge this cycle's kept lanes into the gathered line
  always_comb begin
    m_uops = uops_q;
    m_tkn  = tkn_q;
    for (int s = 0; s < LINE_UOPS; s++) begin
      for (int l = 0; l < DEC_LANES; l++) begin
        if (lane_keep[l] && lane_pos[l] == POS_W'(s))
          m_uops[s*UOP_W +: UOP_W] = dec_uops[l*UOP_W +: UOP_W];
      end
      if (dec_taken && brk_keep && brk_pos == POS_W'(s)) m_tkn[s] = 1'b1;
    end
  end

  assign commit   = step && ((new_cnt == CNT_W'(LINE_UOPS)) || dec_end);
  assign store    = commit && (new_cnt != '0);
  assign out_vld  = LINE_UOPS'(low_mask(int'(new_cnt)));
  assign out_tkn  = m_tkn;
  assign out_uops = m_uops;

  always_ff @(posedge clk) begin
    if (!rst_n || clear || commit) begin
      cnt_q  <= '0;
      uops_q <= '0;
      tkn_q  <= '0;
    end else if (step) begin
      cnt_q  <= new_cnt;
      uops_q <= m_uops;
      tkn_q  <= m_tkn;
    end
  end

  p_cnt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LINE_UOPS));
  p_close_resets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt_q == '0));
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/tc_store.sv
module tc_store #(
  parameter int NLINES = 8,
  parameter int TAG_W  = 13,
  parameter int LW     = 108,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [LW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [LW-1:0]    rd_data
);
  logic [NLINES-1:0]             valid_q;
  logic [NLINES-1:0][TAG_W-1:0]  tag_q;
  logic [NLINES-1:0][LW-1:0]     data_q;

  for (genvar e = 0; e < NLINES; e++) begin : g_ent
    logic sel;
    assign sel = wr_en && !flush && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n || flush) valid_q[e] <= 1'b0;
      else if (sel)        valid_q[e] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e]  <= wr_tag;
        data_q[e] <= wr_data;
      end
    end
  end

  assign rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data = data_q[rd_idx];

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

// File: rtl/trace_line_cache.sv
module trace_line_cache
  import tc_pkg::*;
#(
  parameter int UOP_W     = tc_pkg::UOP_W,
  parameter int LINE_UOPS = tc_pkg::LINE_UOPS,
  parameter int DEC_LANES = tc_pkg::DEC_LANES,
  parameter int ADDR_W    = tc_pkg::ADDR_W,
  parameter int NLINES    = tc_pkg::NLINES,
  localparam int IDX_W = $clog2(NLINES),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int LW    = 2*LINE_UOPS + LINE_UOPS*UOP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        fetch_req,
  input  logic [ADDR_W-1:0]           fetch_addr,
  output logic                        fetch_rdy,
  output logic                        hit,
  output logic                        miss,
  output logic                        dec_en,
  input  logic [DEC_LANES-1:0]        dec_mask,
  input  logic [DEC_LANES*UOP_W-1:0]  dec_uops,
  input  logic                        dec_taken,
  input  logic                        dec_end,
  output logic [LINE_UOPS-1:0]        line_vld,
  output logic [LINE_UOPS-1:0]        line_tkn,
  output logic [LINE_UOPS*UOP_W-1:0]  line_uops
);
  typedef enum logic {ST_IDLE, ST_FILL} state_t;

  state_t              state_q;
  logic [ADDR_W-1:0]   fill_addr_q;
  logic                hit_q, miss_q;
  logic [LW-1:0]       line_q;

  // named internal events
  logic                ev_accept, ev_lookup_hit, ev_start_fill, ev_commit, ev_store;
  logic [LW-1:0]       rd_data;
  logic [LINE_UOPS-1:0]       f_vld, f_tkn;
  logic [LINE_UOPS*UOP_W-1:0] f_uops;

  assign fetch_rdy     = (state_q == ST_IDLE) && !hit_q;
  assign dec_en        = (state_q == ST_FILL);
  assign ev_accept     = fetch_req && fetch_rdy && !flush;
  assign ev_start_fill = ev_accept && !ev_lookup_hit;

  tc_store #(.NLINES(NLINES), .TAG_W(TAG_W), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(ev_store),
    .wr_idx(fill_addr_q[IDX_W-1:0]), .wr_tag(fill_addr_q[ADDR_W-1:IDX_W]),
    .wr_data({f_vld, f_tkn, f_uops}),
    .rd_idx(fetch_addr[IDX_W-1:0]), .rd_tag(fetch_addr[ADDR_W-1:IDX_W]),
    .rd_hit(ev_lookup_hit), .rd_data(rd_data)
  );

  tc_fill #(.LINE_UOPS(LINE_UOPS), .DEC_LANES(DEC_LANES), .UOP_W(UOP_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .clear(flush || ev_start_fill), .step(dec_en),
    .dec_mask(dec_mask), .dec_uops(dec_uops), .dec_taken(dec_taken), .dec_end(dec_end),
    .commit(ev_commit), .store(ev_store),
    .out_vld(f_vld), .out_tkn(f_tkn), .out_uops(f_uops)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      fill_addr_q <= '0;
      hit_q       <= 1'b0;
      miss_q      <= 1'b0;
      line_q      <= '0;
    end else if (flush) begin
      state_q <= ST_IDLE;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      hit_q  <= ev_accept && ev_lookup_hit;
      miss_q <= ev_start_fill;
      if (ev_accept && ev_lookup_hit) line_q <= rd_data;
      if (ev_start_fill) begin
        state_q     <= ST_FILL;
        fill_addr_q <= fetch_addr;
      end else if (dec_en && ev_commit) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign hit       = hit_q;
  assign miss      = miss_q;
  assign line_vld  = line_q[LW-1 -: LINE_UOPS];
  assign line_tkn  = line_q[LINE_UOPS*UOP_W +: LINE_UOPS];
  assign line_uops = line_q[LINE_UOPS*UOP_W-1:0];

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));
  p_miss_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> dec_en);
  p_hit_no_decode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !dec_en);
  p_hit_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
  p_rdy_low_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !fetch_rdy);
  p_slots_packed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((line_vld & (line_vld + 1'b1)) == '0));
  p_tkn_in_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((line_tkn & ~line_vld) == '0));
  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!dec_en && !hit && !miss));
endmodule

// File: tb/sim_trace_line_cache.sv
module sim_trace_line_cache;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_rdy, hit, miss, dec_en;
  logic [3:0]  dec_mask = '0;
  logic [63:0] dec_uops = '0;
  logic        dec_taken = 1'b0;
  logic        dec_end = 1'b0;
  logic [5:0]  line_vld, line_tkn;
  logic [95:0] line_uops;

  int checks = 0, fails = 0, cyc = 0;
  int last_hit = 0, prev_hit = 0;

  trace_line_cache u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_rdy(fetch_rdy), .hit(hit), .miss(miss),
    .dec_en(dec_en), .dec_mask(dec_mask), .dec_uops(dec_uops),
    .dec_taken(dec_taken), .dec_end(dec_end), .line_vld(line_vld),
    .line_tkn(line_tkn), .line_uops(line_uops)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // reference store
  logic        m_v[8];
  logic [12:0] m_tag[8];
  logic [5:0]  m_vld[8], m_tkn[8];
  logic [95:0] m_uops[8];
  int          fb_cnt;
  logic [95:0] fb_uops;
  logic [5:0]  fb_tkn;
  logic [15:0] fb_addr;

  typedef struct {
    bit          is_miss;
    logic [5:0]  vld, tkn;
    logic [95:0] uops;
    string       req;
  } exp_t;
  exp_t q[$];

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fb_reset();
    fb_cnt = 0; fb_uops = '0; fb_tkn = '0;
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
  endtask

  task automatic fetch(input logic [15:0] a, input string req);
    exp_t e;
    int ix;
    @(negedge clk);
    while (!fetch_rdy) @(negedge clk);
    ix = int'(a[2:0]);
    e.req = req;
    if (m_v[ix] && m_tag[ix] == a[15:3]) begin
      e.is_miss = 0; e.vld = m_vld[ix]; e.tkn = m_tkn[ix]; e.uops = m_uops[ix];
    end else begin
      e.is_miss = 1; e.vld = '0; e.tkn = '0; e.uops = '0;
      fb_reset(); fb_addr = a;
    end
    q.push_back(e);
    fetch_req = 1'b1; fetch_addr = a;
    @(posedge clk); #1;
    fetch_req = 1'b0;
  endtask

  // one decoded instruction; the model only gathers while the block decodes
  task automatic dec_step(input logic [3:0] m, input logic [63:0] u, input logic tk, input logic en);
    logic last_kept;
    int   last_slot;
    int   ix;
    dec_mask = m; dec_uops = u; dec_taken = tk; dec_end = en;
    if (dec_en) begin
      last_kept = 0; last_slot = 0;
      for (int l = 0; l < 4; l++) begin
        if (m[l]) begin
          if (fb_cnt < 6) begin
            fb_uops[fb_cnt*16 +: 16] = u[l*16 +: 16];
            last_kept = 1; last_slot = fb_cnt; fb_cnt++;
          end else last_kept = 0;
        end
      end
      if (tk && last_kept) fb_tkn[last_slot] = 1'b1;
      if (fb_cnt == 6 || en) begin
        if (fb_cnt > 0) begin
          ix = int'(fb_addr[2:0]);
          m_v[ix] = 1'b1; m_tag[ix] = fb_addr[15:3];
          m_vld[ix] = 6'((1 << fb_cnt) - 1); m_tkn[ix] = fb_tkn; m_uops[ix] = fb_uops;
        end
        fb_reset();
      end
    end
    @(posedge clk); #1;
    dec_mask = '0; dec_uops = '0; dec_taken = 1'b0; dec_end = 1'b0;
  endtask

  // monitor: pops expected outcomes as the design reports them
  always @(negedge clk) begin
    if (rst_n && (hit || miss)) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected outcome actual=hit%0d/miss%0d expected=none", hit, miss);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.req, 128'(miss), 128'(e.is_miss), "miss flag");
        if (!e.is_miss && hit) begin
          check(e.req, 128'(line_vld), 128'(e.vld), "slot valid");
          check(e.req, 128'(line_tkn), 128'(e.tkn), "taken bits");
          check(e.req, 128'(line_uops), 128'(e.uops), "uops");
          check("R8", 128'(fetch_rdy), 128'(0), "rdy during hit");
          check("R7", 128'(dec_en), 128'(0), "decoder idle on hit");
        end
        if (hit) begin prev_hit = last_hit; last_hit = cyc; end
      end
    end
  end

  initial begin
    #(CLK_P*200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_clear(); fb_reset(); fb_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", 128'(hit), 128'(0), "hit after reset");
    check("R1", 128'(miss), 128'(0), "miss after reset");
    check("R1", 128'(dec_en), 128'(0), "dec_en after reset");
    check("R1", 128'(fetch_rdy), 128'(1), "fetch_rdy after reset");

    // R2/R4/R5: overrun the sixth slot, taken branch mid-line
    fetch(16'h0040, "R1");
    check("R2", 128'(dec_en), 128'(1), "dec_en after miss");
    dec_step(4'b0011, 64'h0000_0000_A002_A001, 1'b0, 1'b0);
    check("R2", 128'(dec_en), 128'(1), "dec_en held mid-fill");
    dec_step(4'b0101, 64'h0000_B003_0000_B001, 1'b1, 1'b0);
    check("R5", 128'(dec_en), 128'(1), "taken does not close line");
    dec_step(4'b1111, 64'hC004_C003_C002_C001, 1'b1, 1'b0);
    check("R4", 128'(dec_en), 128'(0), "fill ends at six");
    fetch(16'h0040, "R4");

    // R3: decoder activity while idle is ignored
    dec_step(4'b1111, 64'hDEAD_BEEF_DEAD_BEEF, 1'b1, 1'b1);
    dec_step(4'b0001, 64'h0000_0000_0000_1234, 1'b0, 1'b1);
    fetch(16'h0040, "R3");

    // R6: sparse masks, early end
    fetch(16'h0013, "R2");
    dec_step(4'b1000, 64'h1111_0000_0000_0000, 1'b0, 1'b0);
    dec_step(4'b0110, 64'h0000_2222_3333_0000, 1'b1, 1'b1);
    check("R6", 128'(dec_en), 128'(0), "end marker closes line");
    fetch(16'h0013, "R6");

    // R8: back-to-back hits two cycles apart
    fetch(16'h0040, "R8");
    fetch(16'h0013, "R8");
    @(negedge clk); @(negedge clk);
    check("R8", 128'(last_hit - prev_hit), 128'(2), "hit spacing");

    // R6: empty trace stores nothing
    fetch(16'h0025, "R6");
    dec_step(4'b0000, 64'h0, 1'b0, 1'b1);
    check("R6", 128'(dec_en), 128'(0), "empty trace ends fill");
    fetch(16'h0025, "R6");
    dec_step(4'b1111, 64'h4004_4003_4002_4001, 1'b0, 1'b0);
    dec_step(4'b0011, 64'h0000_0000_5002_5001, 1'b1, 1'b0);
    fetch(16'h0025, "R5");

    // R9: same index, different tag replaces
    fetch(16'h0140, "R9");
    dec_step(4'b0001, 64'h0000_0000_0000_6001, 1'b0, 1'b1);
    fetch(16'h0040, "R9");
    dec_step(4'b0010, 64'h0000_0000_7001_0000, 1'b0, 1'b1);
    fetch(16'h0140, "R9");
    dec_step(4'b0001, 64'h0000_0000_0000_6002, 1'b0, 1'b1);
    fetch(16'h0140, "R9");

    // R10: flush mid-fill
    fetch(16'h0016, "R10");
    dec_step(4'b0011, 64'h0000_0000_8002_8001, 1'b0, 1'b0);
    flush = 1'b1; model_clear(); fb_reset();
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    check("R10", 128'(dec_en), 128'(0), "dec_en after flush");
    check("R10", 128'(hit | miss), 128'(0), "outcomes after flush");
    fetch(16'h0016, "R10");
    dec_step(4'b0001, 64'h0000_0000_0000_9001, 1'b0, 1'b1);
    fetch(16'h0013, "R10");
    dec_step(4'b0001, 64'h0000_0000_0000_9002, 1'b0, 1'b1);
    fetch(16'h0016, "R7");
    fetch(16'h0013, "R7");

    repeat (4) @(negedge clk);
    check("R7", 128'(q.size()), 128'(0), "all outcomes seen");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule